// File: doc/BRIEF.md
# Byte-Wide Slave Data Port with Status Flag

This block is the 8-bit slave-side data port of a cipher coprocessor. An external host moves bytes through a bidirectional bus. A transfer is qualified only while both an active-low select and an active-low strobe are low. Configuration inputs choose the transfer direction. A qualified write captures the bus byte and hands it to the input holding register. A qualified read drives the output holding register's byte onto the bus and pops that register once, when the strobe is released.

The port also drives an active-low status flag. In single-port configuration, and in dual-port configuration with the output register on this port, the flag is asserted whenever the output register holds data. In dual-port configuration with the input register on this port, the flag shows that the input register has room. It does so only after a start command has armed it. Any other command disarms it until the next start. The holding registers and the command decoder lie outside the block. Only their full/empty signals and one-cycle command strobes reach it.

Top module: `byte_slave_port`

## Requirements
- R1: After reset, `in_wr` and `out_rd` are low, the flag is disarmed, and `flag_n` is high in dual-port input configuration.
- R2: A strobe with `sel_n` high causes no `in_wr`, no `out_rd` and no bus drive.
- R3: The select is not latched: with `sel_n` held low permanently, each strobe still completes one transfer.
- R4: The port reads the bus (host write) when `cfg_dual`=1 and `cfg_slave_in`=1, or when `cfg_dual`=0 and `cfg_single_rd`=0. Otherwise it drives the bus (host read). `in_wr` and `out_rd` are never high together.
- R5: The bus is driven with `out_data` only while `sel_n`=0, `strb_n`=0 and the direction is host read. Otherwise it is released.
- R6: A qualified host write raises `in_wr` for exactly one cycle. That cycle follows the second rising clock edge after the strobe returns high. `in_data` then holds the last byte sampled while the transfer was qualified. The strobe must stay low for at least 3 clock cycles.
- R7: A host write that ends while `in_full`=1 raises no `in_wr`.
- R8: A qualified host read raises `out_rd` for exactly one cycle per strobe, with the same timing as R6. It raises none when `out_empty`=1.
- R9: In single-port configuration, `flag_n` = `out_empty`.
- R10: In dual-port input configuration, `flag_n` is low exactly when the flag is armed and `in_full`=0.
- R11: `cmd_start` arms the flag from the next cycle. `cmd_other` without `cmd_start` disarms it from the next cycle. When both arrive in the same cycle, the start wins.
- R12: In dual-port output configuration, `flag_n` = `out_empty`, whatever the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low select, combinational |
| strb_n | input | 1 | Active-low data strobe |
| bus | inout | 8 | Bidirectional host data bus |
| flag_n | output | 1 | Active-low status flag |
| cfg_dual | input | 1 | 1 = dual-port configuration |
| cfg_slave_in | input | 1 | Dual-port: 1 = input register on this port |
| cfg_single_rd | input | 1 | Single-port: 1 = host reads |
| cmd_start | input | 1 | One-cycle strobe: start command accepted |
| cmd_other | input | 1 | One-cycle strobe: any other command accepted |
| in_full | input | 1 | Input holding register full |
| in_wr | output | 1 | One-cycle push into input register |
| in_data | output | 8 | Byte pushed with `in_wr` |
| out_empty | input | 1 | Output holding register empty |
| out_data | input | 8 | Head byte of output register |
| out_rd | output | 1 | One-cycle pop of output register |

## Verification
The bench sweeps every configuration, armed state and full/empty combination of the flag. A design that ignored the armed state, or mixed up which register the flag follows, shows a wrong level in one of those cells. Transfers are tried with the select high, with the select tied low, and against a full or empty register. A port that latched the select, or pushed into a full register, misses or adds a pulse. The bench counts pulses per strobe and checks the captured byte. A design that pulsed on both strobe edges, or sampled the bus after release, is caught this way. Simultaneous start and other commands pin down which one wins.

// File: rtl/bsp_pkg.sv
`timescale 1ns/1ps
package bsp_pkg;
  typedef struct packed {
    logic dual;
    logic slave_in;
    logic single_rd;
  } port_cfg_t;

  // host reads the bus (port drives it) for this configuration
  function automatic logic host_reads(port_cfg_t c);
    if (c.dual) return !c.slave_in;
    return c.single_rd;
  endfunction

  // flag active (high-true) for this configuration and state
  function automatic logic flag_active(port_cfg_t c, logic armed,
                                       logic in_full, logic out_empty);
    if (c.dual && c.slave_in) return armed && !in_full;
    return !out_empty;
  endfunction
endpackage

// File: rtl/bsp_strobe_sync.sv
`timescale 1ns/1ps
module bsp_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,
  output logic done
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[CHAIN-2:0], qual};
  end

  // trailing edge of the synchronised qualified strobe
  assign done = hist[CHAIN-1] && !hist[CHAIN-2];

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/bsp_xfer.sv
`timescale 1ns/1ps
module bsp_xfer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         qual,
  input  logic         reads,
  input  logic         done,
  input  logic [W-1:0] bus_in,
  input  logic         in_full,
  input  logic         out_empty,
  output logic         in_wr,
  output logic [W-1:0] in_data,
  output logic         out_rd
);
  logic [W-1:0] hold_q;
  logic         wr_evt, rd_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (qual && !reads) hold_q <= bus_in;
  end

  assign wr_evt  = done && !reads;
  assign rd_evt  = done && reads;
  assign in_wr   = wr_evt && !in_full;
  assign out_rd  = rd_evt && !out_empty;
  assign in_data = hold_q;

  // R7
  wr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wr |-> !in_full);
  // R8
  rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_rd |-> !out_empty);
  // R4
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_wr, out_rd}));
  // R8
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_rd |=> !out_rd);
endmodule

// File: rtl/bsp_flag.sv
`timescale 1ns/1ps
module bsp_flag
  import bsp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  port_cfg_t cfg,
  input  logic      cmd_start,
  input  logic      cmd_other,
  input  logic      in_full,
  input  logic      out_empty,
  output logic      flag_n
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (cmd_start) armed_q <= 1'b1;
    else if (cmd_other) armed_q <= 1'b0;
  end

  assign flag_n = !flag_active(cfg, armed_q, in_full, out_empty);

  // R11
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_other && !cmd_start) |=> !armed_q);
  // R11
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> armed_q);
  // R10
  dual_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.dual && cfg.slave_in && in_full) |-> flag_n);
endmodule

// File: rtl/byte_slave_port.sv
`timescale 1ns/1ps
module byte_slave_port
  import bsp_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_n,
  input  logic         strb_n,
  inout  wire  [W-1:0] bus,
  output logic         flag_n,
  input  logic         cfg_dual,
  input  logic         cfg_slave_in,
  input  logic         cfg_single_rd,
  input  logic         cmd_start,
  input  logic         cmd_other,
  input  logic         in_full,
  output logic         in_wr,
  output logic [W-1:0] in_data,
  input  logic         out_empty,
  input  logic [W-1:0] out_data,
  output logic         out_rd
);
  port_cfg_t cfg;
  logic      qual, reads, drive, done;

  assign cfg   = '{dual: cfg_dual, slave_in: cfg_slave_in, single_rd: cfg_single_rd};
  assign qual  = !sel_n && !strb_n;
  assign reads = host_reads(cfg);
  assign drive = qual && reads;
  assign bus   = drive ? out_data : {W{1'bz}};

  bsp_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .qual(qual), .done(done));

  bsp_xfer #(.W(W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .qual(qual), .reads(reads), .done(done),
    .bus_in(bus), .in_full(in_full), .out_empty(out_empty),
    .in_wr(in_wr), .in_data(in_data), .out_rd(out_rd));

  bsp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cmd_start(cmd_start),
    .cmd_other(cmd_other), .in_full(in_full), .out_empty(out_empty),
    .flag_n(flag_n));

  // R5
  drive_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> (!sel_n && !strb_n));
endmodule

// File: tb/byte_slave_port_test.sv
`timescale 1ns/1ps
module byte_slave_port_test;
  logic clk = 0, rst_n = 0;
  logic sel_n = 1, strb_n = 1;
  logic cfg_dual = 1, cfg_slave_in = 1, cfg_single_rd = 0;
  logic cmd_start = 0, cmd_other = 0, in_full = 0, out_empty = 1;
  logic [7:0] out_data = 8'h00, tb_drv = 8'h00;
  logic tb_en = 0;
  logic flag_n, in_wr, out_rd;
  logic [7:0] in_data;
  wire  [7:0] bus;
  int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0;
  logic [7:0] wr_byte = 8'h00;
  bit finished = 0;

  assign bus = tb_en ? tb_drv : 8'bz;

  always #2.5 clk = ~clk;

  byte_slave_port uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .strb_n(strb_n), .bus(bus),
    .flag_n(flag_n), .cfg_dual(cfg_dual), .cfg_slave_in(cfg_slave_in),
    .cfg_single_rd(cfg_single_rd), .cmd_start(cmd_start), .cmd_other(cmd_other),
    .in_full(in_full), .in_wr(in_wr), .in_data(in_data), .out_empty(out_empty),
    .out_data(out_data), .out_rd(out_rd));

  always @(negedge clk) begin
    if (in_wr) begin wr_cnt++; wr_byte = in_data; end
    if (out_rd) rd_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic s, input logic o);
    @(negedge clk); cmd_start = s; cmd_other = o;
    @(negedge clk); cmd_start = 0; cmd_other = 0;
  endtask

  // one strobe; returns pulse counts and bus value seen mid-strobe
  task automatic xfer(input logic sel_low, input logic wr, input logic [7:0] d,
                      output int nwr, output int nrd, output logic [7:0] seen);
    int w0, r0;
    @(negedge clk);
    w0 = wr_cnt; r0 = rd_cnt;
    sel_n = !sel_low; tb_en = wr; tb_drv = d; strb_n = 0;
    repeat (3) @(negedge clk);
    seen = bus;
    strb_n = 1;
    repeat (2) @(negedge clk);
    tb_en = 0;
    repeat (3) @(negedge clk);
    nwr = wr_cnt - w0; nrd = rd_cnt - r0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int nw, nr;
    logic [7:0] sb;
    repeat (3) @(negedge clk);
    // R1 reset state, dual input config
    chk("R1 flag_n", flag_n, 1);
    chk("R1 in_wr", in_wr, 0);
    chk("R1 out_rd", out_rd, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flag_n after release", flag_n, 1);

    // R9/R10/R12 flag sweep
    for (int a = 0; a < 2; a++) begin
      if (a == 1) cmd(1, 0); else cmd(0, 1);
      for (int c = 0; c < 8; c++) begin
        for (int fe = 0; fe < 4; fe++) begin
          logic exp_act;
          @(negedge clk);
          cfg_dual = c[2]; cfg_slave_in = c[1]; cfg_single_rd = c[0];
          in_full = fe[1]; out_empty = fe[0];
          #1;
          if (c[2] && c[1]) exp_act = (a == 1) && (fe[1] == 0);
          else              exp_act = (fe[0] == 0);
          if (!c[2])      chk("R9 single flag", flag_n, !exp_act);
          else if (c[1])  chk("R10 dual-in flag", flag_n, !exp_act);
          else            chk("R12 dual-out flag", flag_n, !exp_act);
        end
      end
    end

    // R11 ordering of commands
    @(negedge clk); cfg_dual = 1; cfg_slave_in = 1; in_full = 0;
    cmd(0, 1); #1 chk("R11 other disarms", flag_n, 1);
    cmd(1, 1); #1 chk("R11 start wins", flag_n, 0);
    cmd(0, 1); #1 chk("R11 other disarms again", flag_n, 1);
    cmd(1, 0); #1 chk("R11 start arms", flag_n, 0);

    // R6 host writes in dual input config
    foreach (sb[i]) ;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v = 8'h3C ^ (8'(k) * 8'h51);
      xfer(1, 1, v, nw, nr, sb);
      chk("R6 one push", nw, 1);
      chk("R6 byte", wr_byte, v);
      chk("R4 no pop on write", nr, 0);
    end
    // R7 full
    in_full = 1;
    xfer(1, 1, 8'hA5, nw, nr, sb);
    chk("R7 no push when full", nw, 0);
    in_full = 0;
    // R2 select high
    xfer(0, 1, 8'h5A, nw, nr, sb);
    chk("R2 no push unselected", nw, 0);
    // R3 select tied low across strobes
    sel_n = 0;
    xfer(1, 1, 8'hC3, nw, nr, sb);
    chk("R3 push with sel tied", nw, 1);
    chk("R3 byte", wr_byte, 8'hC3);
    xfer(1, 1, 8'h96, nw, nr, sb);
    chk("R3 second push", nw, 1);
    chk("R3 second byte", wr_byte, 8'h96);

    // R8/R5 host reads in dual output config
    cfg_slave_in = 0; out_empty = 0;
    for (int k = 0; k < 3; k++) begin
      out_data = 8'h11 + 8'(k) * 8'h22;
      xfer(1, 0, 8'h00, nw, nr, sb);
      chk("R5 bus driven", sb, out_data);
      chk("R8 one pop", nr, 1);
      chk("R4 no push on read", nw, 0);
    end
    out_empty = 1;
    xfer(1, 0, 8'h00, nw, nr, sb);
    chk("R8 no pop when empty", nr, 0);
    out_empty = 0;
    // R2 unselected read: bench drives bus, no pop
    xfer(0, 1, 8'h77, nw, nr, sb);
    chk("R2 bus not driven", sb, 8'h77);
    chk("R2 no pop unselected", nr, 0);

    // R4 single-port directions
    cfg_dual = 0; cfg_single_rd = 1; out_data = 8'hE7;
    xfer(1, 0, 8'h00, nw, nr, sb);
    chk("R4 single read bus", sb, 8'hE7);
    chk("R4 single read pop", nr, 1);
    cfg_single_rd = 0;
    xfer(1, 1, 8'h4B, nw, nr, sb);
    chk("R4 single write push", nw, 1);
    chk("R4 single write byte", wr_byte, 8'h4B);
    chk("R4 single write no pop", nr, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule